// File: doc/BRIEF.md
# Protected Oscillator Control Register

This block is a single 32-bit control word for an external oscillator, reachable through a plain write port (address, write strobe, data) and a combinational read port. It decodes the word into individual configuration fields, which go to the oscillator start-up sequencer and the clock failure detector. The word sits behind three layers of protection.

The first layer is a lock bit. Once software sets it, the lock holds until reset, and it freezes every field except the switch-back enable. The second layer makes the configuration fields read-only while the oscillator enable is 1. The third layer is a legality rule: auto gain can never be 1 while crystal mode is 0. The oscillator logic also drives a hardware pulse that clears the switch-back enable once the output has returned to the external source.

The lock and enable bits are held in a four-state mode machine:
- ST_OPEN: unlocked and disabled.
- ST_RUN: unlocked and enabled.
- ST_SEALED_OFF: locked and disabled.
- ST_SEALED_RUN: locked and enabled.

The mode machine has these transitions:
- From ST_OPEN or ST_RUN, a write that hits the register moves the machine to the state encoded by the written lock and enable bits. These transitions are open-to-run, run-to-open, open-to-sealed and run-to-sealed; a write that selects the current state is a self-loop.
- ST_SEALED_OFF and ST_SEALED_RUN have only self-loops until reset.

Top module: `osc_ctl_top`

## Requirements
- R1: After reset the register reads 0x00000D00. The startup field is 0xD and every other bit is 0.
- R2: A write with bus_we=1 and bus_addr equal to REG_ADDR updates the permitted fields at the next rising clock edge. The field positions are:
  - bit 31: lock
  - bits 25:24: reference divider select
  - bits 19:16: detector prescaler
  - bits 11:8: startup select
  - bit 7: on-demand
  - bit 5: switch-back enable
  - bit 4: detector enable
  - bit 3: crystal mode
  - bit 2: auto gain
  - bit 1: enable

  A write to any other address changes nothing. bus_rdata shows the register when bus_addr equals REG_ADDR, and 0 otherwise.
- R3: While the lock is 1, writes change no bit except switch-back enable, and the lock stays 1 until reset.
- R4: While the enable (as held before the write) is 1, writes leave these fields unchanged: divider, prescaler, startup, on-demand, detector enable, crystal mode and auto gain. Enable, lock and switch-back remain writable.
- R5: The auto gain bit takes the value of the written auto gain bit ANDed with the resulting crystal mode. It is therefore never 1 while crystal mode is 0. The other permitted fields of the same write still take effect.
- R6: A sb_clear pulse clears switch-back enable at the next edge. If it coincides with a write of 1 to that bit, the clear wins.
- R7: Bits 30:26, 23:20, 15:12, 6 and 0 always read 0 and ignore writes.
- R8: Lock and enable follow the mode machine: ST_OPEN and ST_RUN take their next state from a hitting write, and the sealed states are left only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Access address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 on address miss |
| sb_clear | input | 1 | Hardware clear of switch-back enable |
| cfg_lock | output | 1 | Lock bit |
| cfg_enable | output | 1 | Oscillator enable |
| cfg_xtal | output | 1 | Crystal mode (0 = external clock input) |
| cfg_agc | output | 1 | Auto gain loop enable |
| cfg_det_en | output | 1 | Clock failure detector enable |
| cfg_swback | output | 1 | Switch-back enable |
| cfg_ondemand | output | 1 | On-demand operation |
| cfg_startup | output | 4 | Start-up time select |
| cfg_presc | output | 4 | Detector prescaler |
| cfg_refdiv | output | 2 | Reference divider select |

## Verification
The assertions check the following on every cycle:
- Auto gain implies crystal mode.
- The lock never falls once set.
- Every gated field holds steady across a cycle that starts with enable or lock set.
- A hardware clear empties the switch-back bit.
- Unimplemented bits and missed reads return zeros.

The bench's scenarios are needed for behaviour that depends on the written value. These cases are the reset value, full write-and-read-back, and the rejected auto gain request while the rest of that write still lands. They also cover the write that disables the oscillator while its other fields stay frozen, the hardware-versus-software collision, and the switch-back exception under lock.

// File: rtl/osc_ctl_pkg.sv
package osc_ctl_pkg;
    localparam int DATA_W  = 32;
    localparam int LOCK_B  = 31;
    localparam int DIV_LSB = 24;
    localparam int DIV_W   = 2;
    localparam int PRE_LSB = 16;
    localparam int PRE_W   = 4;
    localparam int STU_LSB = 8;
    localparam int STU_W   = 4;
    localparam int OND_B   = 7;
    localparam int SWB_B   = 5;
    localparam int DET_B   = 4;
    localparam int XTL_B   = 3;
    localparam int AGC_B   = 2;
    localparam int EN_B    = 1;

    localparam logic [STU_W-1:0] STU_RST = 4'hD;

    function automatic logic [DATA_W-1:0] impl_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        m[LOCK_B] = 1'b1;
        for (int i = 0; i < DIV_W; i++) m[DIV_LSB+i] = 1'b1;
        for (int i = 0; i < PRE_W; i++) m[PRE_LSB+i] = 1'b1;
        for (int i = 0; i < STU_W; i++) m[STU_LSB+i] = 1'b1;
        m[OND_B] = 1'b1;
        m[SWB_B] = 1'b1;
        m[DET_B] = 1'b1;
        m[XTL_B] = 1'b1;
        m[AGC_B] = 1'b1;
        m[EN_B]  = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] IMPL_MASK = impl_mask();

    // Encoding is {lock, enable}.
    typedef enum logic [1:0] {
        ST_OPEN       = 2'b00,
        ST_RUN        = 2'b01,
        ST_SEALED_OFF = 2'b10,
        ST_SEALED_RUN = 2'b11
    } mode_e;

    typedef struct packed {
        logic [DIV_W-1:0] refdiv;
        logic [PRE_W-1:0] presc;
        logic [STU_W-1:0] startup;
        logic             ondemand;
        logic             det_en;
        logic             xtal;
        logic             agc;
    } cfg_t;
endpackage

// File: rtl/osc_ctl_mode.sv
module osc_ctl_mode
    import osc_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic req_lock,
    input  logic req_en,
    output logic lock,
    output logic enable
);
    mode_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OPEN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OPEN, ST_RUN: begin
                if (wr_hit) begin
                    unique case ({req_lock, req_en})
                        2'b00: state_nx = ST_OPEN;
                        2'b01: state_nx = ST_RUN;
                        2'b10: state_nx = ST_SEALED_OFF;
                        2'b11: state_nx = ST_SEALED_RUN;
                        default: state_nx = state;
                    endcase
                end
            end
            ST_SEALED_OFF: state_nx = ST_SEALED_OFF;
            ST_SEALED_RUN: state_nx = ST_SEALED_RUN;
            default:       state_nx = ST_OPEN;
        endcase
    end

    always_comb begin
        lock   = 1'b0;
        enable = 1'b0;
        unique case (state)
            ST_OPEN:       begin lock = 1'b0; enable = 1'b0; end
            ST_RUN:        begin lock = 1'b0; enable = 1'b1; end
            ST_SEALED_OFF: begin lock = 1'b1; enable = 1'b0; end
            ST_SEALED_RUN: begin lock = 1'b1; enable = 1'b1; end
            default:       begin lock = 1'b0; enable = 1'b0; end
        endcase
    end
endmodule

// File: rtl/osc_ctl_fields.sv
module osc_ctl_fields
    import osc_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic lock,
    input  logic enable,
    input  logic sb_clear,
    input  cfg_t w_cfg,
    input  logic w_swb,
    output cfg_t cfg,
    output logic swback
);
    logic cfg_wr;
    cfg_t cfg_nx;

    // Gated fields move only when unlocked and the oscillator is off.
    assign cfg_wr = wr_hit && !lock && !enable;

    always_comb begin
        cfg_nx = cfg;
        if (cfg_wr) cfg_nx = w_cfg;
        // Legality rule: auto gain needs crystal mode.
        cfg_nx.agc = cfg_nx.agc & cfg_nx.xtal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg         <= '0;
            cfg.startup <= STU_RST;
        end else begin
            cfg <= cfg_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        swback <= 1'b0;
        else if (sb_clear) swback <= 1'b0;
        else if (wr_hit)   swback <= w_swb;
    end
endmodule

// File: rtl/osc_ctl_top.sv
module osc_ctl_top
    import osc_ctl_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              sb_clear,
    output logic              cfg_lock,
    output logic              cfg_enable,
    output logic              cfg_xtal,
    output logic              cfg_agc,
    output logic              cfg_det_en,
    output logic              cfg_swback,
    output logic              cfg_ondemand,
    output logic [3:0]        cfg_startup,
    output logic [3:0]        cfg_presc,
    output logic [1:0]        cfg_refdiv
);
    logic addr_hit, wr_hit, unused_wbits;
    cfg_t w_cfg, cfg;
    logic [DATA_W-1:0] word;

    assign addr_hit     = (bus_addr == REG_ADDR);
    assign wr_hit       = bus_we && addr_hit;
    assign unused_wbits = ^(bus_wdata & ~IMPL_MASK);

    assign w_cfg.refdiv   = bus_wdata[DIV_LSB +: DIV_W];
    assign w_cfg.presc    = bus_wdata[PRE_LSB +: PRE_W];
    assign w_cfg.startup  = bus_wdata[STU_LSB +: STU_W];
    assign w_cfg.ondemand = bus_wdata[OND_B];
    assign w_cfg.det_en   = bus_wdata[DET_B];
    assign w_cfg.xtal     = bus_wdata[XTL_B];
    assign w_cfg.agc      = bus_wdata[AGC_B];

    osc_ctl_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_hit),
        .req_lock (bus_wdata[LOCK_B]),
        .req_en   (bus_wdata[EN_B]),
        .lock     (cfg_lock),
        .enable   (cfg_enable)
    );

    osc_ctl_fields u_fields (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_hit),
        .lock     (cfg_lock),
        .enable   (cfg_enable),
        .sb_clear (sb_clear),
        .w_cfg    (w_cfg),
        .w_swb    (bus_wdata[SWB_B]),
        .cfg      (cfg),
        .swback   (cfg_swback)
    );

    assign cfg_xtal     = cfg.xtal;
    assign cfg_agc      = cfg.agc;
    assign cfg_det_en   = cfg.det_en;
    assign cfg_ondemand = cfg.ondemand;
    assign cfg_startup  = cfg.startup;
    assign cfg_presc    = cfg.presc;
    assign cfg_refdiv   = cfg.refdiv;

    always_comb begin
        word = '0;
        word[LOCK_B]             = cfg_lock;
        word[DIV_LSB +: DIV_W]   = cfg.refdiv;
        word[PRE_LSB +: PRE_W]   = cfg.presc;
        word[STU_LSB +: STU_W]   = cfg.startup;
        word[OND_B]              = cfg.ondemand;
        word[SWB_B]              = cfg_swback;
        word[DET_B]              = cfg.det_en;
        word[XTL_B]              = cfg.xtal;
        word[AGC_B]              = cfg.agc;
        word[EN_B]               = cfg_enable;
    end

    assign bus_rdata = addr_hit ? word : '0;
endmodule

// File: rtl/osc_ctl_chk.sv
module osc_ctl_chk
    import osc_ctl_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              sb_clear,
    input logic              cfg_lock,
    input logic              cfg_enable,
    input logic              cfg_xtal,
    input logic              cfg_agc,
    input logic              cfg_det_en,
    input logic              cfg_swback,
    input logic              cfg_ondemand,
    input logic [3:0]        cfg_startup,
    input logic [3:0]        cfg_presc,
    input logic [1:0]        cfg_refdiv
);
    logic [15:0] gated;
    assign gated = {cfg_refdiv, cfg_presc, cfg_startup, cfg_ondemand,
                    cfg_det_en, cfg_xtal, cfg_agc, 2'b00};

    p_agc_xtal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_agc |-> cfg_xtal);

    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_lock |=> cfg_lock);

    p_lock_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_lock |=> ($stable(gated) && $stable(cfg_enable)));

    p_run_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_enable |=> $stable(gated));

    p_hw_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sb_clear |=> !cfg_swback);

    p_unimpl_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~IMPL_MASK) == 32'h0);

    p_read_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != REG_ADDR) |-> (bus_rdata == 32'h0));
endmodule

bind osc_ctl_top osc_ctl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .sb_clear     (sb_clear),
    .cfg_lock     (cfg_lock),
    .cfg_enable   (cfg_enable),
    .cfg_xtal     (cfg_xtal),
    .cfg_agc      (cfg_agc),
    .cfg_det_en   (cfg_det_en),
    .cfg_swback   (cfg_swback),
    .cfg_ondemand (cfg_ondemand),
    .cfg_startup  (cfg_startup),
    .cfg_presc    (cfg_presc),
    .cfg_refdiv   (cfg_refdiv)
);

// File: tb/sim_osc_ctl_top.sv
`timescale 1ns/1ps
module sim_osc_ctl_top;
    localparam logic [7:0] RA = 8'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = RA;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sb_clear = 1'b0;
    logic        cfg_lock, cfg_enable, cfg_xtal, cfg_agc, cfg_det_en;
    logic        cfg_swback, cfg_ondemand;
    logic [3:0]  cfg_startup, cfg_presc;
    logic [1:0]  cfg_refdiv;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    osc_ctl_top #(.ADDR_W(8), .REG_ADDR(RA)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sb_clear(sb_clear),
        .cfg_lock(cfg_lock), .cfg_enable(cfg_enable), .cfg_xtal(cfg_xtal),
        .cfg_agc(cfg_agc), .cfg_det_en(cfg_det_en), .cfg_swback(cfg_swback),
        .cfg_ondemand(cfg_ondemand), .cfg_startup(cfg_startup),
        .cfg_presc(cfg_presc), .cfg_refdiv(cfg_refdiv)
    );

    // Monitor: pops one expected item per falling edge and compares.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: actual=%08h expected=%08h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic clr);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d; sb_clear = clr;
        @(posedge clk); #1;
        bus_we = 1'b0; sb_clear = 1'b0; bus_addr = RA;
    endtask

    task automatic expect_read(input logic [7:0] a, input logic [31:0] e, input string t);
        bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        wait (exp_q.size() == 0);
        #1 bus_addr = RA;
    endtask

    task automatic direct(input bit ok, input string t, input logic [31:0] act, input logic [31:0] e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", t, act, e);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%08h expected=%08h", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        expect_read(RA, 32'h00000D00, "R1 reset value");
        direct(cfg_startup == 4'hD && !cfg_lock && !cfg_enable, "R1 reset fields",
               {28'h0, cfg_startup}, 32'hD);
        expect_read(8'h24, 32'h0, "R2 read on address miss");
        wr(8'h24, 32'hFFFF_FFFF, 1'b0);
        expect_read(RA, 32'h00000D00, "R2 write on address miss ignored");
        wr(RA, 32'h020A0A98, 1'b0);
        expect_read(RA, 32'h020A0A98, "R2 field write");
        direct(cfg_refdiv == 2'd2 && cfg_presc == 4'hA && cfg_ondemand && cfg_det_en,
               "R2 decoded fields", {30'h0, cfg_refdiv}, 32'h2);
        wr(RA, 32'h7FFF_FFFD, 1'b0);
        expect_read(RA, 32'h030F0FBC, "R7 unimplemented bits read zero");
        wr(RA, 32'h00000D04, 1'b0);
        expect_read(RA, 32'h00000D00, "R5 auto gain without crystal");
        wr(RA, 32'h00000D0C, 1'b0);
        expect_read(RA, 32'h00000D0C, "R5 auto gain with crystal");
        wr(RA, 32'h01050304, 1'b0);
        expect_read(RA, 32'h01050300, "R5 rest of write lands");
        wr(RA, 32'h0000050E, 1'b0);
        expect_read(RA, 32'h0000050E, "R8 open to run");
        wr(RA, 32'h030F0FB2, 1'b0);
        expect_read(RA, 32'h0000052E, "R4 fields frozen while enabled");
        wr(RA, 32'h0, 1'b1);
        expect_read(RA, 32'h0000050C, "R4 disable write keeps fields");
        wr(RA, 32'h00000020, 1'b0);
        expect_read(RA, 32'h00000020, "R6 switch-back set");
        @(posedge clk); #1 sb_clear = 1'b1;
        @(posedge clk); #1 sb_clear = 1'b0;
        expect_read(RA, 32'h00000000, "R6 hardware clear");
        wr(RA, 32'h00000020, 1'b1);
        expect_read(RA, 32'h00000000, "R6 clear beats write");
        wr(RA, 32'h80000D02, 1'b0);
        expect_read(RA, 32'h80000D02, "R8 open to sealed run");
        wr(RA, 32'h00000000, 1'b0);
        expect_read(RA, 32'h80000D02, "R3 locked write ignored");
        direct(cfg_lock && cfg_enable, "R8 sealed state holds", {31'h0, cfg_lock}, 32'h1);
        wr(RA, 32'h00000020, 1'b0);
        expect_read(RA, 32'h80000D22, "R3 switch-back writable under lock");
        @(posedge clk); #1 sb_clear = 1'b1;
        @(posedge clk); #1 sb_clear = 1'b0;
        expect_read(RA, 32'h80000D02, "R6 hardware clear under lock");
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule